// File: doc/BRIEF.md
# Dynamic-Sizing Bus Cycle Sequencer

This block is the external bus master on the processor side of a chip. It takes one operand transfer request at a time and runs as many external bus cycles as the responding port needs to move the whole operand. A request carries a byte address, an operand length of one to four bytes, a direction, a 3-bit address-space code and a lock flag. Each cycle ends when the port acknowledges with its width. The sequencer advances the address by the bytes that port actually took, and keeps going until no bytes remain.

The block runs on a clock at twice the bus rate, so one clock of this block is half a bus clock. Each bus cycle uses three phases: an address phase, a strobe phase that stretches until the acknowledge arrives, and a termination phase. The size code reports the bytes still owed, not the width of the current cycle. A responder can therefore decide from the size code and the low address bits which lanes it serves. The lock output runs across a whole read-modify-write pair. The direction output changes only when the direction actually changes.

Top module: `dyn_bus_seq`

## Requirements
- R1: The address, size code, space code and direction outputs change together when a bus cycle starts. They stay unchanged for every clock in which the address strobe is high.
- R2: The address strobe rises one clock after the cycle's address phase begins. It stays high while the acknowledge is 00. It falls on the clock after a nonzero acknowledge is sampled.
- R3: The size code gives the operand bytes still to transfer. The encoding is 01 for one byte, 10 for two bytes, 11 for three bytes and 00 for four bytes. The request's length input uses the same encoding.
- R4: The operand-start output is high for exactly one clock per request. That clock is the address phase of the first bus cycle.
- R5: The acknowledge codes are 00 for wait, 01 for an 8-bit port, 10 for a 16-bit port and 11 for a 32-bit port. On acknowledge, the bytes taken are the smaller of the bytes remaining and the port width minus (address modulo port width). The address and the remaining count move by that amount, and a new cycle starts while bytes remain.
- R6: The direction output is 1 for read and 0 for write. It changes only at the start of a request whose direction differs from the one before it, so it stays low without a break across consecutive writes.
- R7: A request with the lock flag set raises the lock output at the start of its first cycle. The lock output then stays high until the final cycle of the locked write that follows completes. It is low for unlocked requests.
- R8: The done output pulses for one clock during the termination phase of the final cycle. The ready output is high only when the block is idle. A request presented while the block is busy is ignored.
- R9: During and after reset the strobe, operand-start, lock and done outputs are low, the direction output is 1 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this clock |
| req_addr | input | AW | Operand byte address (most significant byte) |
| req_siz | input | 2 | Operand length, encoded as the size code |
| req_write | input | 1 | 1 for a write |
| req_fc | input | 3 | Address-space code |
| req_lock | input | 1 | Request belongs to a read-modify-write pair |
| port_ack | input | 2 | Cycle acknowledge and port width |
| addr_o | output | AW | Bus address |
| siz_o | output | 2 | Bytes remaining |
| fc_o | output | 3 | Address-space code |
| rw_o | output | 1 | Direction, 1 read, 0 write |
| as_o | output | 1 | Address strobe |
| ocs_o | output | 1 | First cycle of an operand |
| rmc_o | output | 1 | Locked sequence in progress |
| done_o | output | 1 | Request complete |

## Verification
The assertions assume several things about the inputs. The acknowledge is nonzero only while the strobe is high. Requests arrive only while ready is high, or are ignored when they do not. A locked read is always followed by its locked write before any other request. The bench models a responder that drives the acknowledge only on clocks where it sees the strobe high, with zero to two wait clocks. It clears the acknowledge in the termination phase. It pairs every locked read with a locked write, and it raises a request while the block is busy only to confirm that the request has no effect.

// File: rtl/dyn_bus_seq.sv
module dyn_bus_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_siz,
  input  logic          req_write,
  input  logic [2:0]    req_fc,
  input  logic          req_lock,
  input  logic [1:0]    port_ack,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    siz_o,
  output logic [2:0]    fc_o,
  output logic          rw_o,
  output logic          as_o,
  output logic          ocs_o,
  output logic          rmc_o,
  output logic          done_o
);
  typedef enum logic [1:0] {IDLE, ADR, STRB, TERM} st_t;

  st_t        st;
  logic [2:0] rem, pw, off, avail, take;
  logic       lock_q;

  assign pw    = port_ack == 2'b11 ? 3'd4 : port_ack == 2'b10 ? 3'd2 : 3'd1;
  assign off   = port_ack == 2'b11 ? {1'b0, addr_o[1:0]} :
                 port_ack == 2'b10 ? {2'b00, addr_o[0]} : 3'd0;
  assign avail = pw - off;
  assign take  = rem < avail ? rem : avail;

  assign siz_o     = rem[1:0];
  assign as_o      = st == STRB;
  assign done_o    = st == TERM && rem == 3'd0;
  assign req_ready = st == IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= IDLE;
      rem    <= 3'd0;
      addr_o <= '0;
      fc_o   <= 3'd0;
      rw_o   <= 1'b1;
      ocs_o  <= 1'b0;
      rmc_o  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      ocs_o <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          addr_o <= req_addr;
          rem    <= {req_siz == 2'b00, req_siz};
          fc_o   <= req_fc;
          rw_o   <= ~req_write;
          lock_q <= req_lock;
          ocs_o  <= 1'b1;
          if (req_lock) rmc_o <= 1'b1;
          st     <= ADR;
        end
        ADR: st <= STRB;
        STRB: if (port_ack != 2'b00) begin
          addr_o <= addr_o + AW'(take);
          rem    <= rem - take;
          st     <= TERM;
        end
        TERM: begin
          if (rem == 3'd0) begin
            st <= IDLE;
            if (!lock_q || !rw_o) rmc_o <= 1'b0;
          end else begin
            st <= ADR;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r1_held_under_strobe: assert property (@(posedge clk) disable iff (rst)
    as_o && $past(as_o) |-> $stable(addr_o) && $stable(siz_o) && $stable(fc_o) && $stable(rw_o));

  a_r2_strobe_drops_after_ack: assert property (@(posedge clk) disable iff (rst)
    as_o && port_ack != 2'b00 |=> !as_o);

  a_r4_start_outside_strobe: assert property (@(posedge clk) disable iff (rst)
    ocs_o |-> !as_o && !done_o);

  a_r6_dir_moves_at_start: assert property (@(posedge clk) disable iff (rst)
    rw_o != $past(rw_o) |-> ocs_o);

  a_r7_lock_ends_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(rmc_o) |-> $past(done_o));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o && req_ready);
endmodule

// File: tb/sim_dyn_bus_seq.sv
module sim_dyn_bus_seq;
  localparam time CLK_T = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_siz = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_fc = '0;
  logic        req_lock = 1'b0;
  logic [1:0]  port_ack = '0;
  logic [31:0] addr_o;
  logic [1:0]  siz_o;
  logic [2:0]  fc_o;
  logic        rw_o, as_o, ocs_o, rmc_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_wr = 0;
  int rw_bad = 0;

  always #(CLK_T/2) clk = ~clk;

  dyn_bus_seq #(.AW(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_siz(req_siz), .req_write(req_write),
    .req_fc(req_fc), .req_lock(req_lock), .port_ack(port_ack),
    .addr_o(addr_o), .siz_o(siz_o), .fc_o(fc_o), .rw_o(rw_o), .as_o(as_o),
    .ocs_o(ocs_o), .rmc_o(rmc_o), .done_o(done_o)
  );

  always @(negedge clk) if (mon_wr && rw_o !== 1'b0) rw_bad++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // addr[16:9] bytes[8:6] ack[5:4] wr[3] cycles[2:0]
  localparam int NV = 11;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {8'h00, 3'd4, 2'b11, 1'b0, 3'd1},
    {8'h01, 3'd4, 2'b11, 1'b1, 3'd2},
    {8'h03, 3'd2, 2'b11, 1'b1, 3'd2},
    {8'h02, 3'd1, 2'b11, 1'b0, 3'd1},
    {8'h00, 3'd4, 2'b10, 1'b0, 3'd2},
    {8'h01, 3'd4, 2'b10, 1'b1, 3'd3},
    {8'h01, 3'd3, 2'b10, 1'b0, 3'd2},
    {8'h02, 3'd2, 2'b10, 1'b0, 3'd1},
    {8'h05, 3'd4, 2'b01, 1'b1, 3'd4},
    {8'h00, 3'd3, 2'b01, 1'b0, 3'd3},
    {8'h07, 3'd1, 2'b01, 1'b1, 3'd1}
  };

  task automatic do_op(input logic [31:0] a, input int nbytes, input bit wr,
                       input bit lock, input logic [1:0] ack, input int waits,
                       input bit intrude, output int ncyc);
    logic [31:0] ea;
    logic [2:0]  fcx;
    int er, wc, pw, tk, ocs_n, as_n;
    bit prev_as, fin;
    fcx = a[2:0] ^ 3'd5;
    @(negedge clk);
    req_addr = a; req_siz = nbytes[1:0]; req_write = wr; req_fc = fcx;
    req_lock = lock; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ea = a; er = nbytes; ncyc = 0; wc = waits; ocs_n = 0; as_n = 0;
    prev_as = 0; fin = 0;
    pw = ack == 2'b11 ? 4 : ack == 2'b10 ? 2 : 1;
    chk(as_o == 1'b0, "R2", "strobe low in first address phase", 32'(as_o), 0);
    chk(rmc_o == lock, "R7", "lock at first cycle", 32'(rmc_o), 32'(lock));
    for (int g = 0; g < 200; g++) begin
      if (ocs_o) ocs_n++;
      if (as_o) as_n++;
      if (as_o && !prev_as) begin
        ncyc++;
        chk(siz_o == er[1:0], "R3", "size code", 32'(siz_o), 32'(er[1:0]));
        chk(addr_o == ea, "R5", "cycle address", addr_o, ea);
        chk(rw_o == !wr, "R6", "direction", 32'(rw_o), 32'(!wr));
        chk(fc_o == fcx, "R1", "space code", 32'(fc_o), 32'(fcx));
      end
      if (as_o) begin
        if (wc == 0) begin
          port_ack = ack;
          tk = pw - int'(ea % pw);
          if (er < tk) tk = er;
          ea = ea + tk; er = er - tk; wc = waits;
        end else begin
          port_ack = 2'b00; wc--;
        end
        if (intrude && ncyc == 1) begin req_valid = 1'b1; req_addr = 32'hFF; end
      end else begin
        port_ack = 2'b00;
        req_valid = 1'b0;
      end
      prev_as = as_o;
      if (done_o) begin fin = 1; break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(fin, "R8", "done seen", 32'(fin), 1);
    chk(ocs_n == 1, "R4", "operand start count", ocs_n, 1);
    chk(er == 0, "R5", "bytes left", er, 0);
    chk(as_n == ncyc * (waits + 1), "R2", "strobe clocks", as_n, ncyc * (waits + 1));
  endtask

  initial begin
    #(CLK_T * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nc;
    repeat (3) @(negedge clk);
    chk(as_o == 0 && ocs_o == 0 && rmc_o == 0 && done_o == 0, "R9", "idle outputs in reset",
        {as_o, ocs_o, rmc_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rw_o == 1 && req_ready == 1, "R9", "direction and ready after reset", {rw_o, req_ready}, 3);

    for (int i = 0; i < NV; i++) begin
      do_op({24'h0, VEC[i][16:9]}, int'(VEC[i][8:6]), VEC[i][3], 1'b0, VEC[i][5:4], i % 3, 1'b0, nc);
      chk(nc == int'(VEC[i][2:0]), "R5", "cycle count", nc, VEC[i][2:0]);
    end

    // R8: done is one clock, then idle
    do_op(32'h40, 2, 1'b0, 1'b0, 2'b11, 0, 1'b0, nc);
    @(negedge clk);
    chk(done_o == 0 && req_ready == 1, "R8", "done one clock then ready", {done_o, req_ready}, 1);

    // R8: request while busy has no effect
    do_op(32'h10, 2, 1'b0, 1'b0, 2'b01, 1, 1'b1, nc);
    chk(nc == 2, "R8", "busy request ignored, cycles", nc, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(as_o == 0 && req_ready == 1, "R8", "no extra cycle after busy request", {as_o, req_ready}, 1);
    end

    // R6: consecutive writes keep direction low
    do_op(32'h21, 3, 1'b1, 1'b0, 2'b10, 0, 1'b0, nc);
    mon_wr = 1;
    do_op(32'h33, 4, 1'b1, 1'b0, 2'b01, 1, 1'b0, nc);
    mon_wr = 0;
    chk(rw_bad == 0, "R6", "direction glitch across writes", rw_bad, 0);
    do_op(32'h08, 1, 1'b0, 1'b0, 2'b11, 0, 1'b0, nc);

    // R7: locked read then locked write
    do_op(32'h51, 4, 1'b0, 1'b1, 2'b10, 0, 1'b0, nc);
    @(negedge clk);
    chk(rmc_o == 1, "R7", "lock held between read and write", 32'(rmc_o), 1);
    do_op(32'h51, 4, 1'b1, 1'b1, 2'b10, 1, 1'b0, nc);
    chk(rmc_o == 1, "R7", "lock held through final cycle", 32'(rmc_o), 1);
    @(negedge clk);
    chk(rmc_o == 0, "R7", "lock released after write", 32'(rmc_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule